// File: doc/BRIEF.md
# Two-Level Local History Direction Predictor

This block guesses whether a conditional branch will be taken. It predicts in two levels. The first level is a small set of per-branch shift registers, and a few address bits pick one of them. Each register holds the most recent outcomes of the branches that map to it. The second level is one table of 2-bit saturating counters that every branch shares. The selected history value is the index into that table, and the upper bit of the chosen counter is the prediction. Because each history value has its own counter, the block can learn short repeating patterns. A strictly alternating branch is one example: a single counter keeps getting it wrong, but this block predicts it correctly once its history has filled.

A fetch stage drives a branch address on the lookup port and reads the predicted direction back in the same cycle. When the branch resolves, the execute stage presents its address and real outcome on the update port. Each update trains one counter and shifts the outcome into that branch's history.

Top module: `bp_local2l`

## Requirements
- R1: After reset every counter holds weakly not taken (binary 01) and every history register holds zero. As a result, a lookup at any address predicts not taken.
- R2: The lookup is combinational. `lk_taken` equals bit 1 of the counter whose index is the current history of the register selected by `lk_pc`.
- R3: A taken update adds one to the selected counter. The counter stops at 3 (strongly taken) and does not wrap.
- R4: A not-taken update subtracts one from the selected counter. The counter stops at 0 (strongly not taken) and does not wrap.
- R5: An update trains the counter indexed by the branch's history as it was before the update. In the same clock edge, the outcome (1 = taken) enters that history at bit 0, the older bits move up one place, and the oldest bit is dropped.
- R6: The history register is selected by address bits [4:2] only, which gives 8 registers. Addresses that differ only in other bits share a register. Updating one register leaves the other seven unchanged.
- R7: The counter table is shared. Any branch whose history equals a given value reads the counter that another branch trained under that same history value.
- R8: A branch that strictly alternates taken and not taken is predicted correctly on every occurrence once a few warm-up occurrences have passed.
- R9: If a lookup and an update to the same register happen in the same cycle, the lookup returns the prediction from the state before that update.
- R10: When `up_valid` is low, no counter or history changes, whatever `up_pc` and `up_taken` hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lk_pc | input | PC_W | Address of the branch being predicted |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| up_valid | input | 1 | Resolved-branch update strobe |
| up_pc | input | PC_W | Address of the resolved branch |
| up_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
The bound checker watches each update every cycle. It checks that the counter chosen by the old history moves by one and stops at the ends, that the same branch's history takes the new outcome at bit 0, and that nothing changes on a cycle without an update. Some behaviours only the bench scenarios can show: the reset prediction, the same-cycle lookup seeing the state from before the update, counters shared across different branches, and an alternating branch reaching zero mispredictions after warm-up. The bench compares every lookup against a model built from the requirements, and it adds hand-worked expected values at the points where the update ordering matters.

// File: rtl/bp_pkg.sv
package bp_pkg;

  // 2-bit direction counter states, ordered so that bit 1 is the prediction
  typedef enum logic [1:0] {
    CTR_SNT = 2'b00,
    CTR_WNT = 2'b01,
    CTR_WT  = 2'b10,
    CTR_ST  = 2'b11
  } ctr_e;

  localparam ctr_e CTR_RESET = CTR_WNT;

  // Saturating step toward the resolved direction
  function automatic ctr_e ctr_step(input ctr_e cur, input logic taken);
    ctr_e nxt;
    nxt = cur;
    if (taken) begin
      if (cur != CTR_ST) nxt = ctr_e'(cur + 2'd1);
    end else begin
      if (cur != CTR_SNT) nxt = ctr_e'(cur - 2'd1);
    end
    return nxt;
  endfunction

  function automatic logic ctr_dir(input ctr_e cur);
    return cur[1];
  endfunction

endpackage

// File: rtl/bp_hist_table.sv
module bp_hist_table #(
  parameter int IDX_W  = 3,
  parameter int HIST_W = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [IDX_W-1:0]              rd_a_idx,
  output logic [HIST_W-1:0]             rd_a_hist,
  input  logic [IDX_W-1:0]              rd_b_idx,
  output logic [HIST_W-1:0]             rd_b_hist,
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              wr_idx,
  input  logic                          wr_taken,
  output logic [(1<<IDX_W)*HIST_W-1:0]  state_o
);

  localparam int N_ENT = 1 << IDX_W;

  logic [HIST_W-1:0] hist_q [N_ENT];
  logic [HIST_W:0]   shift_w;

  // Outcome enters at bit 0; oldest outcome falls off the top
  assign shift_w = {hist_q[wr_idx], wr_taken};

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_ENT; i++) hist_q[i] <= '0;
    end else if (wr_en) begin
      hist_q[wr_idx] <= shift_w[HIST_W-1:0];
    end
  end

  assign rd_a_hist = hist_q[rd_a_idx];
  assign rd_b_hist = hist_q[rd_b_idx];

  for (genvar g = 0; g < N_ENT; g++) begin : g_flat
    assign state_o[g*HIST_W +: HIST_W] = hist_q[g];
  end

endmodule

// File: rtl/bp_pht.sv
module bp_pht
  import bp_pkg::*;
#(
  parameter int HIST_W = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [HIST_W-1:0]            rd_idx,
  output logic                         rd_dir,
  input  logic                         wr_en,
  input  logic [HIST_W-1:0]            wr_idx,
  input  logic                         wr_taken,
  output logic [(1<<HIST_W)*2-1:0]     state_o
);

  localparam int N_CTR = 1 << HIST_W;

  ctr_e ctr_q [N_CTR];
  ctr_e ctr_nxt;

  assign ctr_nxt = ctr_step(ctr_q[wr_idx], wr_taken);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_CTR; i++) ctr_q[i] <= CTR_RESET;
    end else if (wr_en) begin
      ctr_q[wr_idx] <= ctr_nxt;
    end
  end

  assign rd_dir = ctr_dir(ctr_q[rd_idx]);

  for (genvar g = 0; g < N_CTR; g++) begin : g_flat
    assign state_o[g*2 +: 2] = ctr_q[g];
  end

endmodule

// File: rtl/bp_local2l.sv
module bp_local2l #(
  parameter int PC_W   = 32,
  parameter int IDX_LO = 2,
  parameter int IDX_W  = 3,
  parameter int HIST_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_taken,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken
);

  localparam int N_ENT = 1 << IDX_W;
  localparam int N_CTR = 1 << HIST_W;
  localparam int IDX_HI = IDX_LO + IDX_W;

  logic [IDX_W-1:0]          lk_idx;
  logic [IDX_W-1:0]          up_idx;
  logic [HIST_W-1:0]         lk_hist;
  logic [HIST_W-1:0]         up_hist;
  logic [N_ENT*HIST_W-1:0]   hist_state;
  logic [N_CTR*2-1:0]        pht_state;
  logic                      unused_pc_bits;

  assign lk_idx = lk_pc[IDX_LO +: IDX_W];
  assign up_idx = up_pc[IDX_LO +: IDX_W];

  assign unused_pc_bits = ^{lk_pc[PC_W-1:IDX_HI], lk_pc[IDX_LO-1:0],
                            up_pc[PC_W-1:IDX_HI], up_pc[IDX_LO-1:0]};

  bp_hist_table #(
    .IDX_W (IDX_W),
    .HIST_W(HIST_W)
  ) u_hist (
    .clk      (clk),
    .rst      (rst),
    .rd_a_idx (lk_idx),
    .rd_a_hist(lk_hist),
    .rd_b_idx (up_idx),
    .rd_b_hist(up_hist),
    .wr_en    (up_valid),
    .wr_idx   (up_idx),
    .wr_taken (up_taken),
    .state_o  (hist_state)
  );

  // Training uses the history read before this edge's shift
  bp_pht #(
    .HIST_W(HIST_W)
  ) u_pht (
    .clk     (clk),
    .rst     (rst),
    .rd_idx  (lk_hist),
    .rd_dir  (lk_taken),
    .wr_en   (up_valid),
    .wr_idx  (up_hist),
    .wr_taken(up_taken),
    .state_o (pht_state)
  );

endmodule

// File: rtl/bp_local2l_chk.sv
module bp_local2l_chk #(
  parameter int PC_W   = 32,
  parameter int IDX_LO = 2,
  parameter int IDX_W  = 3,
  parameter int HIST_W = 2
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          up_valid,
  input logic [PC_W-1:0]               up_pc,
  input logic                          up_taken,
  input logic [(1<<IDX_W)*HIST_W-1:0]  hist_state,
  input logic [(1<<HIST_W)*2-1:0]      pht_state
);

  logic [IDX_W-1:0]  c_idx, p_idx;
  logic [HIST_W-1:0] c_hist, p_hist, hist_at_prev;
  logic [1:0]        c_ctr, p_ctr, ctr_at_prev;
  logic              p_taken;
  logic [HIST_W:0]   exp_shift;
  logic              unused_chk_bits;

  assign unused_chk_bits = ^{up_pc[PC_W-1:IDX_LO+IDX_W], up_pc[IDX_LO-1:0]};

  assign c_idx  = up_pc[IDX_LO +: IDX_W];
  assign c_hist = hist_state[c_idx*HIST_W +: HIST_W];
  assign c_ctr  = pht_state[c_hist*2 +: 2];

  always_ff @(posedge clk) begin
    p_idx   <= c_idx;
    p_hist  <= c_hist;
    p_ctr   <= c_ctr;
    p_taken <= up_taken;
  end

  assign ctr_at_prev  = pht_state[p_hist*2 +: 2];
  assign hist_at_prev = hist_state[p_idx*HIST_W +: HIST_W];
  assign exp_shift    = {p_hist, p_taken};

  // R3: taken moves the old-history counter up by one
  p_ctr_inc_r3: assert property (@(posedge clk) disable iff (rst)
    (up_valid && up_taken && c_ctr != 2'd3) |=> (ctr_at_prev == p_ctr + 2'd1));

  // R3: strongly taken stays put
  p_ctr_sat_hi_r3: assert property (@(posedge clk) disable iff (rst)
    (up_valid && up_taken && c_ctr == 2'd3) |=> (ctr_at_prev == 2'd3));

  // R4: not taken moves the counter down by one
  p_ctr_dec_r4: assert property (@(posedge clk) disable iff (rst)
    (up_valid && !up_taken && c_ctr != 2'd0) |=> (ctr_at_prev == p_ctr - 2'd1));

  // R4: strongly not taken stays put
  p_ctr_sat_lo_r4: assert property (@(posedge clk) disable iff (rst)
    (up_valid && !up_taken && c_ctr == 2'd0) |=> (ctr_at_prev == 2'd0));

  // R5: history gains the outcome at bit 0
  p_hist_shift_r5: assert property (@(posedge clk) disable iff (rst)
    up_valid |=> (hist_at_prev == exp_shift[HIST_W-1:0]));

  // R10: no update strobe, no state change
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !up_valid |=> ($stable(pht_state) && $stable(hist_state)));

endmodule

bind bp_local2l bp_local2l_chk #(
  .PC_W  (PC_W),
  .IDX_LO(IDX_LO),
  .IDX_W (IDX_W),
  .HIST_W(HIST_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .up_valid  (up_valid),
  .up_pc     (up_pc),
  .up_taken  (up_taken),
  .hist_state(hist_state),
  .pht_state (pht_state)
);

// File: tb/tb_bp_local2l.sv
module tb_bp_local2l;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] lk_pc;
  logic        lk_taken;
  logic        up_valid;
  logic [31:0] up_pc;
  logic        up_taken;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  bit [1:0] m_ctr  [4];
  bit [1:0] m_hist [8];

  always #5 clk = ~clk;

  bp_local2l dut (
    .clk     (clk),
    .rst     (rst),
    .lk_pc   (lk_pc),
    .lk_taken(lk_taken),
    .up_valid(up_valid),
    .up_pc   (up_pc),
    .up_taken(up_taken)
  );

  function automatic bit [31:0] pc_of(int idx, int salt);
    return (32'(salt) << 5) | (32'(idx) << 2) | 32'(salt & 3);
  endfunction

  function automatic bit m_pred(bit [31:0] pc);
    return m_ctr[m_hist[pc[4:2]]][1];
  endfunction

  task automatic chk(string req, bit act, bit exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: lk_taken=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic look(string req, bit [31:0] pc, bit exp);
    lk_pc = pc;
    #1;
    chk(req, lk_taken, exp);
  endtask

  task automatic look_m(string req, bit [31:0] pc);
    look(req, pc, m_pred(pc));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; up_valid = 1'b0; up_pc = '0; up_taken = 1'b0; lk_pc = '0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 4; i++) m_ctr[i] = 2'b01;
    for (int i = 0; i < 8; i++) m_hist[i] = 2'b00;
  endtask

  task automatic m_upd(bit [31:0] pc, bit t);
    bit [1:0] h;
    h = m_hist[pc[4:2]];
    if (t && m_ctr[h] != 2'd3) m_ctr[h]++;
    if (!t && m_ctr[h] != 2'd0) m_ctr[h]--;
    m_hist[pc[4:2]] = {h[0], t};
  endtask

  task automatic upd(bit [31:0] pc, bit t);
    up_valid = 1'b1; up_pc = pc; up_taken = t;
    @(negedge clk);
    up_valid = 1'b0;
    m_upd(pc, t);
  endtask

  task automatic t_reset();
    do_reset();
    for (int i = 0; i < 8; i++) look("R1", pc_of(i, i * 7), 1'b0);
  endtask

  task automatic t_saturate();
    do_reset();
    // R4: three not-taken at history 00 pin counter 0 to 00; one taken gives 01
    for (int i = 0; i < 3; i++) upd(pc_of(0, 0), 1'b0);
    upd(pc_of(0, 0), 1'b1);
    look("R4", pc_of(1, 0), 1'b0);
    look_m("R4", pc_of(0, 0));
    // R3: many taken at idx 2 saturate counter 3 without wrapping
    for (int i = 0; i < 8; i++) upd(pc_of(2, 1), 1'b1);
    look("R3", pc_of(2, 1), 1'b1);
    look_m("R3", pc_of(2, 1));
    for (int i = 0; i < 2; i++) upd(pc_of(5, 0), 1'b1);
    look("R3", pc_of(5, 0), 1'b1);
  endtask

  task automatic t_order();
    do_reset();
    // R5: one taken at idx 0 trains counter 0 (old history), history becomes 01
    upd(pc_of(0, 0), 1'b1);
    look("R5", pc_of(1, 0), 1'b1);
    look("R5", pc_of(0, 0), 1'b0);
    // R2: prediction follows the current history of the selected register
    upd(pc_of(0, 0), 1'b0);
    look_m("R2", pc_of(0, 0));
    look_m("R2", pc_of(3, 0));
  endtask

  task automatic t_select();
    do_reset();
    upd(pc_of(3, 5), 1'b1);
    // R6: same bits [4:2], other bits differ -> same history (01 -> counter 1 = 01)
    look("R6", pc_of(3, 9), 1'b0);
    // R7: idx 4 untouched history 00 reads shared counter 0 trained to 10
    look("R7", pc_of(4, 2), 1'b1);
    for (int i = 0; i < 8; i++) look_m("R6", pc_of(i, 3));
  endtask

  task automatic t_idle();
    do_reset();
    upd(pc_of(6, 0), 1'b1);
    for (int i = 0; i < 6; i++) begin
      up_valid = 1'b0; up_pc = pc_of(i, i); up_taken = 1'b1;
      @(negedge clk);
    end
    for (int i = 0; i < 8; i++) look_m("R10", pc_of(i, 0));
    look("R10", pc_of(0, 0), 1'b1);
  endtask

  task automatic t_same_cycle();
    do_reset();
    for (int i = 0; i < 3; i++) upd(pc_of(0, 0), 1'b1);
    // R9: history 11, counter 3 = 10 -> taken before the update lands
    up_valid = 1'b1; up_pc = pc_of(0, 0); up_taken = 1'b0;
    look("R9", pc_of(0, 0), 1'b1);
    @(negedge clk);
    up_valid = 1'b0;
    m_upd(pc_of(0, 0), 1'b0);
    look("R9", pc_of(0, 0), 1'b0);
  endtask

  task automatic t_alternate();
    bit t;
    int miss;
    do_reset();
    t = 1'b1;
    miss = 0;
    for (int i = 0; i < 24; i++) begin
      lk_pc = pc_of(5, 4);
      #1;
      if (i >= 8) begin
        n_run++;
        if (lk_taken !== t) begin
          n_fail++; miss++;
          $display("FAIL R8: step %0d lk_taken=%0b expected=%0b", i, lk_taken, t);
        end
      end
      upd(pc_of(5, 4), t);
      t = ~t;
    end
    look_m("R8", pc_of(5, 4));
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: timeout actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; up_valid = 1'b0; up_pc = '0; up_taken = 1'b0; lk_pc = '0;
    t_reset();
    t_saturate();
    t_order();
    t_select();
    t_idle();
    t_same_cycle();
    t_alternate();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule